// File: doc/BRIEF.md
# Interrupt Status Aggregation Unit

This block holds a 32-bit word of pending interrupt causes for a memory-mapped peripheral. Software can set bits by writing to a raise offset and clear them by writing to an acknowledge offset. Software reads the word back at a status offset. Two internal completion strobes, one for a finished calculation and one for a finished data transfer, each set a fixed bit.

The block signals the host in one of two ways, chosen by a static mode input. In message mode, every raise that leaves the word nonzero produces a one-cycle pulse, including a raise while bits are already pending. In line mode, a raise drives a level output high. That level output falls only when an acknowledge leaves the word at zero.

All state is registered, and a change takes effect one clock after the write or strobe. The read port is combinational.

Top module: `irq_status_agg`

## Requirements
- R1: While reset is active and after its release, the status word is zero and both `irq_line` and `irq_msg` are low.
- R2: A write to offset 0x60 ORs the write data into the status word, which is visible on the next cycle.
- R3: A write to offset 0x64 clears each status bit that is 1 in the write data and leaves the other bits unchanged.
- R4: A read at offset 0x24 returns the status word. A read at any other offset returns all ones.
- R5: `calc_done` sets status bit 0 (0x00000001) and `xfer_done` sets status bit 8 (0x00000100).
- R6: With `msg_mode` high, any raise with a nonzero value gives `irq_msg` high for exactly one cycle, and `irq_line` does not change.
- R7: With `msg_mode` low, any raise with a nonzero value drives `irq_line` high on the next cycle.
- R8: `irq_line` falls only after an acknowledge leaves the status word at zero while `msg_mode` is low. A partial acknowledge keeps it high.
- R9: If an internal strobe and an acknowledge of the same bit occur in one cycle, the bit ends up set.
- R10: A raise write of zero, with no strobe active, leaves the word, `irq_line` and `irq_msg` unchanged.
- R11: With `msg_mode` high, each new nonzero raise while bits are already pending gives a new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data |
| calc_done | input | 1 | Calculation-finished strobe |
| xfer_done | input | 1 | Transfer-finished strobe |
| msg_mode | input | 1 | 1 selects pulse signalling, 0 selects level signalling |
| irq_line | output | 1 | Level interrupt output |
| irq_msg | output | 1 | One-cycle message interrupt pulse |

## Verification
A corrupted status word shows up at the read port in the cycle after the bad update, because reads are combinational. A lost or stuck bit therefore appears on the first read after the faulty write or strobe. A wrong line-hold decision shows as `irq_line` staying high after a full acknowledge, or falling after a partial one, one cycle after the acknowledge. A missing re-fire or a pulse longer than one cycle is visible on `irq_msg` within two cycles of the raise.

// File: rtl/irq_status_agg.sv
module irq_status_agg #(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter logic [AW-1:0] OFS_STAT  = 8'h24,
  parameter logic [AW-1:0] OFS_RAISE = 8'h60,
  parameter logic [AW-1:0] OFS_ACK   = 8'h64,
  parameter int CALC_BIT = 0,
  parameter int XFER_BIT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          calc_done,
  input  logic          xfer_done,
  input  logic          msg_mode,
  output logic          irq_line,
  output logic          irq_msg
);
  localparam logic [DW-1:0] CALC_MASK = DW'(1) << CALC_BIT;
  localparam logic [DW-1:0] XFER_MASK = DW'(1) << XFER_BIT;

  logic [DW-1:0] pend_q, set_v, clr_v, pend_d;
  logic          ack_wr, any_set;

  assign ack_wr  = wr_en && (wr_addr == OFS_ACK);
  assign set_v   = ((wr_en && wr_addr == OFS_RAISE) ? wr_data : '0)
                 | (calc_done ? CALC_MASK : '0)
                 | (xfer_done ? XFER_MASK : '0);
  assign clr_v   = ack_wr ? wr_data : '0;
  assign pend_d  = (pend_q & ~clr_v) | set_v;
  assign any_set = |set_v;
  assign rd_data = (rd_addr == OFS_STAT) ? pend_q : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= '0;
      irq_line <= 1'b0;
      irq_msg  <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      irq_msg <= any_set && msg_mode;
      if (any_set && !msg_mode)
        irq_line <= 1'b1;
      else if (ack_wr && !msg_mode && pend_d == '0)
        irq_line <= 1'b0;
    end
  end
endmodule

module irq_status_agg_chk #(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter logic [AW-1:0] OFS_STAT  = 8'h24,
  parameter logic [AW-1:0] OFS_RAISE = 8'h60,
  parameter logic [AW-1:0] OFS_ACK   = 8'h64,
  parameter int CALC_BIT = 0,
  parameter int XFER_BIT = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic [AW-1:0] rd_addr,
  input logic [DW-1:0] rd_data,
  input logic          calc_done,
  input logic          xfer_done,
  input logic          msg_mode,
  input logic          irq_line,
  input logic          irq_msg,
  input logic [DW-1:0] pend
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (pend == '0 && !irq_line && !irq_msg));
  a_r2_raise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OFS_RAISE) |=> ((pend & $past(wr_data)) == $past(wr_data)));
  a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OFS_ACK && !calc_done && !xfer_done) |=> ((pend & $past(wr_data)) == '0));
  a_r6_msg_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    irq_msg |-> (pend != '0));
  a_r7_line_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_mode && xfer_done) |=> irq_line);
  a_r8_line_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_line) |-> (pend == '0 && !msg_mode));
  a_r9_strobe_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (calc_done && wr_en && wr_addr == OFS_ACK) |=> pend[CALC_BIT]);
  a_r11_refire: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_mode && calc_done) |=> irq_msg);
endmodule

bind irq_status_agg irq_status_agg_chk #(
  .DW(DW), .AW(AW), .OFS_STAT(OFS_STAT), .OFS_RAISE(OFS_RAISE), .OFS_ACK(OFS_ACK),
  .CALC_BIT(CALC_BIT), .XFER_BIT(XFER_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .calc_done(calc_done), .xfer_done(xfer_done),
  .msg_mode(msg_mode), .irq_line(irq_line), .irq_msg(irq_msg), .pend(pend_q)
);

// File: tb/irq_status_agg_tb.sv
module irq_status_agg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = 8'h24;
  logic [31:0] rd_data;
  logic        calc_done = 1'b0;
  logic        xfer_done = 1'b0;
  logic        msg_mode = 1'b0;
  logic        irq_line, irq_msg;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irq_status_agg u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .calc_done(calc_done), .xfer_done(xfer_done),
    .msg_mode(msg_mode), .irq_line(irq_line), .irq_msg(irq_msg)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic stat_is(string req, logic [31:0] exp);
    rd_addr = 8'h24;
    #1 chk(req, rd_data, exp);
  endtask

  task automatic step(logic we, logic [7:0] a, logic [31:0] d, logic c, logic x);
    wr_en = we; wr_addr = a; wr_data = d; calc_done = c; xfer_done = x;
    @(negedge clk);
    wr_en = 1'b0; calc_done = 1'b0; xfer_done = 1'b0; wr_data = '0;
  endtask

  task automatic do_reset(logic mode);
    rst_n = 1'b0; msg_mode = mode;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    stat_is("R1", 32'h0);
    chk("R1", {31'b0, irq_line}, 32'h0);
    chk("R1", {31'b0, irq_msg}, 32'h0);
  endtask

  task automatic t_accum_line;
    do_reset(1'b0);
    step(1'b1, 8'h60, 32'h0000_00f0, 1'b0, 1'b0);
    stat_is("R2", 32'h0000_00f0);
    chk("R7", {31'b0, irq_line}, 32'h1);
    chk("R6", {31'b0, irq_msg}, 32'h0);
    step(1'b1, 8'h60, 32'h8000_0001, 1'b0, 1'b0);
    stat_is("R2", 32'h8000_00f1);
    rd_addr = 8'h20;
    #1 chk("R4", rd_data, 32'hffff_ffff);
    step(1'b1, 8'h64, 32'h0000_0030, 1'b0, 1'b0);
    stat_is("R3", 32'h8000_00c1);
    chk("R8", {31'b0, irq_line}, 32'h1);
    step(1'b1, 8'h64, 32'h8000_00c1, 1'b0, 1'b0);
    stat_is("R3", 32'h0);
    chk("R8", {31'b0, irq_line}, 32'h0);
  endtask

  task automatic t_sources;
    do_reset(1'b0);
    step(1'b0, 8'h0, 32'h0, 1'b1, 1'b0);
    stat_is("R5", 32'h0000_0001);
    step(1'b0, 8'h0, 32'h0, 1'b0, 1'b1);
    stat_is("R5", 32'h0000_0101);
    chk("R7", {31'b0, irq_line}, 32'h1);
    step(1'b1, 8'h64, 32'h0000_0001, 1'b1, 1'b0);
    stat_is("R9", 32'h0000_0101);
    step(1'b1, 8'h64, 32'h0000_0100, 1'b0, 1'b0);
    chk("R8", {31'b0, irq_line}, 32'h1);
    step(1'b1, 8'h64, 32'h0000_0001, 1'b0, 1'b0);
    chk("R8", {31'b0, irq_line}, 32'h0);
    step(1'b1, 8'h60, 32'h0, 1'b0, 1'b0);
    stat_is("R10", 32'h0);
    chk("R10", {31'b0, irq_line}, 32'h0);
  endtask

  task automatic t_msg;
    do_reset(1'b1);
    step(1'b1, 8'h60, 32'h0000_0004, 1'b0, 1'b0);
    chk("R6", {31'b0, irq_msg}, 32'h1);
    chk("R6", {31'b0, irq_line}, 32'h0);
    @(negedge clk);
    chk("R6", {31'b0, irq_msg}, 32'h0);
    step(1'b0, 8'h0, 32'h0, 1'b1, 1'b0);
    chk("R11", {31'b0, irq_msg}, 32'h1);
    stat_is("R11", 32'h0000_0005);
    step(1'b1, 8'h60, 32'h0, 1'b0, 1'b0);
    chk("R10", {31'b0, irq_msg}, 32'h0);
    step(1'b1, 8'h64, 32'h0000_0005, 1'b0, 1'b0);
    stat_is("R3", 32'h0);
    chk("R8", {31'b0, irq_line}, 32'h0);
    chk("R6", {31'b0, irq_msg}, 32'h0);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset();
        t_accum_line();
        t_sources();
        t_msg();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule